// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block moves a programmed number of bytes between one peripheral data port and system memory. It does this without the processor handling any individual word. Software writes a device number, a direction, a memory start address and a byte count into a small register window, then writes a go command. The engine then asks an external arbiter for the shared memory bus. It streams 32-bit words between the device and memory while it holds the grant. When the count runs out it raises an interrupt that stays high until software acknowledges it.

The engine holds the bus for at most a fixed number of words per request. It then drops its request for one cycle and competes again, so other masters on the bus cannot be shut out. Loss of the grant, a memory that is not ready, and a device that is not ready all stall the transfer with no loss of data.

Every move is one word. The memory address therefore steps by 4 and the remaining byte count falls by 4 on each word. Both device sides and the memory side use valid/ready word ports. A word moves in a cycle where the memory side's valid and ready are both high. In that cycle the device-side handshake is high as well.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: The register window decodes `cfg_sel` as follows: 0 is the device number, 1 is the memory start address, 2 is the byte count and 3 is the direction in bit 0. A direction of 0 moves data from the device to memory and 1 moves data from memory to the device. A write to 4 with bit 0 set is the go command. Address 5 is status: busy in bit 0, done in bit 1, error in bit 2. Registers 0 to 3 read back the last accepted value, and `dev_addr` presents the device number.
- R2: A go command with a byte count that is nonzero and a multiple of 4 starts a transfer, so busy reads 1 from the next cycle. Any other count sets the error bit, leaves busy at 0 and raises no bus request.
- R3: `mem_valid` is high only while `bus_req` and `bus_gnt` are both high.
- R4: Device-to-memory words are written to consecutive word addresses from the start address upward, in the order the device presents them, with `mem_we` high.
- R5: Memory-to-device words are read from consecutive word addresses from the start address upward and handed to the device in that order, with `mem_we` low.
- R6: Each moved word lowers the remaining count by 4. After exactly count/4 words, busy falls and `bus_req` drops in the cycle after the last word.
- R7: At most 16 words move during one continuous assertion of `bus_req`. After the 16th word of a transfer that is not yet finished, `bus_req` is low for one cycle before it is raised again.
- R8: Dropping `bus_gnt`, `mem_ready`, `dev_rx_valid` or `dev_tx_ready` for any number of cycles stalls the transfer with no word lost, repeated or skipped, and the memory address does not advance.
- R9: On completion the done bit and `irq` rise, and they stay high until a status write with bit 1 set. A status write with bit 1 clear leaves them high. A status write with bit 2 set clears the error bit.
- R10: While busy, writes to registers 0 to 3 and go commands are ignored. `dev_addr` and the read-back values keep their old contents, and no second transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| mem_valid | output | 1 | Memory access valid |
| mem_ready | input | 1 | Memory accepts the access |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data from memory, valid with the handshake |
| dev_addr | output | 8 | Programmed device number |
| dev_rx_valid | input | 1 | Device offers a word |
| dev_rx_ready | output | 1 | Engine takes the offered word |
| dev_rx_data | input | 32 | Word from the device |
| dev_tx_valid | output | 1 | Engine offers a word to the device |
| dev_tx_ready | input | 1 | Device takes the word |
| dev_tx_data | output | 32 | Word to the device |

## Verification
The bench drives transfers longer than one burst while the grant, the memory and the device all stall on different patterns. A design that dropped or repeated a word on a stall would show a wrong address or data at the next handshake. A design that did not re-arbitrate would keep `bus_req` high past the 16th word. The bench issues go commands and register writes in the middle of a transfer. A controller that honoured them would change `dev_addr`, the read-back values or the number of words delivered. It also tries counts of 6 and 0, which a controller that checked only alignment or only zero would start. It writes the status register with the done bit clear to catch an interrupt that cleared on any status write.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int DEV_W      = 8;
    localparam int CNT_W      = 16;
    localparam int SEL_W      = 3;
    localparam int WORD_BYTES = DATA_W / 8;

    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;
    localparam int STAT_ERR  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DEV   = 3'd0,
        SEL_MADDR = 3'd1,
        SEL_COUNT = 3'd2,
        SEL_DIR   = 3'd3,
        SEL_GO    = 3'd4,
        SEL_STAT  = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_GAP   = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [ADDR_W-1:0] maddr;
        logic [CNT_W-1:0]  count;
        logic              to_dev;
    } xfer_cfg_t;

    function automatic logic count_ok(input logic [CNT_W-1:0] c);
        return (c != '0) && (c[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              fin,
    output xfer_cfg_t         cfg,
    output logic              start,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);

    logic go_wr;
    logic bad_go;
    logic stat_wr;

    always_comb begin
        go_wr   = we && (reg_sel_e'(sel) == SEL_GO) && wdata[0] && !busy;
        start   = go_wr && count_ok(cfg.count);
        bad_go  = go_wr && !count_ok(cfg.count);
        stat_wr = we && (reg_sel_e'(sel) == SEL_STAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (we && !busy) begin
                case (reg_sel_e'(sel))
                    SEL_DEV:   cfg.dev    <= wdata[DEV_W-1:0];
                    SEL_MADDR: cfg.maddr  <= wdata[ADDR_W-1:0];
                    SEL_COUNT: cfg.count  <= wdata[CNT_W-1:0];
                    SEL_DIR:   cfg.to_dev <= wdata[0];
                    default: ;
                endcase
            end
            if (fin)
                done <= 1'b1;
            else if (stat_wr && wdata[STAT_DONE])
                done <= 1'b0;
            if (bad_go)
                err <= 1'b1;
            else if (stat_wr && wdata[STAT_ERR])
                err <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(sel))
            SEL_DEV:   rdata[DEV_W-1:0]  = cfg.dev;
            SEL_MADDR: rdata[ADDR_W-1:0] = cfg.maddr;
            SEL_COUNT: rdata[CNT_W-1:0]  = cfg.count;
            SEL_DIR:   rdata[0]          = cfg.to_dev;
            SEL_STAT: begin
                rdata[STAT_BUSY] = busy;
                rdata[STAT_DONE] = done;
                rdata[STAT_ERR]  = err;
            end
            default: rdata = '0;
        endcase
    end

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg))
        else $error("configuration changed during a transfer");

    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        done && !(stat_wr && wdata[STAT_DONE]) |=> done)
        else $error("done cleared without acknowledge");

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int BURST_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_cfg_t         cfg,
    input  logic              start,
    input  logic              bus_gnt,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_rx_valid,
    input  logic [DATA_W-1:0] dev_rx_data,
    input  logic              dev_tx_ready,
    output logic              busy,
    output logic              fin,
    output logic              bus_req,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dev_rx_ready,
    output logic              dev_tx_valid,
    output logic [DATA_W-1:0] dev_tx_data
);

    localparam int BEAT_W = $clog2(BURST_LEN + 1);

    eng_state_e        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  left;
    logic [BEAT_W-1:0] beat;
    logic              to_dev;

    logic in_burst;
    logic word_ok;
    logic last_word;
    logic burst_end;

    always_comb begin
        in_burst = (state == ST_BURST) && bus_gnt;
        if (to_dev) begin
            mem_valid    = in_burst && dev_tx_ready;
            dev_tx_valid = in_burst && mem_ready;
            dev_rx_ready = 1'b0;
        end else begin
            mem_valid    = in_burst && dev_rx_valid;
            dev_rx_ready = in_burst && mem_ready;
            dev_tx_valid = 1'b0;
        end
        word_ok   = mem_valid && mem_ready;
        last_word = (left == CNT_W'(WORD_BYTES));
        burst_end = (beat == BEAT_W'(BURST_LEN - 1));
    end

    assign bus_req     = (state == ST_BURST);
    assign busy        = (state != ST_IDLE);
    assign fin         = word_ok && last_word;
    assign mem_we      = !to_dev;
    assign mem_addr    = cur_addr;
    assign mem_wdata   = dev_rx_data;
    assign dev_tx_data = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            left     <= '0;
            beat     <= '0;
            to_dev   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_BURST;
                        cur_addr <= cfg.maddr;
                        left     <= cfg.count;
                        to_dev   <= cfg.to_dev;
                        beat     <= '0;
                    end
                end
                ST_BURST: begin
                    if (word_ok) begin
                        cur_addr <= cur_addr + ADDR_W'(WORD_BYTES);
                        left     <= left - CNT_W'(WORD_BYTES);
                        beat     <= beat + 1'b1;
                        if (last_word) begin
                            state <= ST_IDLE;
                        end else if (burst_end) begin
                            state <= ST_GAP;
                            beat  <= '0;
                        end
                    end
                end
                ST_GAP:  state <= ST_BURST;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_bus_owned_R3: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (bus_req && bus_gnt))
        else $error("memory access without bus ownership");

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        busy && !word_ok |=> $stable(mem_addr))
        else $error("address moved during a stall");

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dma_pkg::*;
#(
    parameter int BURST_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              busy,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DEV_W-1:0]  dev_addr,
    input  logic              dev_rx_valid,
    output logic              dev_rx_ready,
    input  logic [DATA_W-1:0] dev_rx_data,
    output logic              dev_tx_valid,
    input  logic              dev_tx_ready,
    output logic [DATA_W-1:0] dev_tx_data
);

    localparam int SEEN_W = $clog2(BURST_LEN + 2);

    xfer_cfg_t cfg;
    logic      start;
    logic      fin;
    logic      done;
    logic      err;

    dma_cfg_regs i_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .busy  (busy),
        .fin   (fin),
        .cfg   (cfg),
        .start (start),
        .done  (done),
        .err   (err),
        .rdata (cfg_rdata)
    );

    dma_engine #(.BURST_LEN(BURST_LEN)) i_engine (
        .clk          (clk),
        .rst          (rst),
        .cfg          (cfg),
        .start        (start),
        .bus_gnt      (bus_gnt),
        .mem_ready    (mem_ready),
        .mem_rdata    (mem_rdata),
        .dev_rx_valid (dev_rx_valid),
        .dev_rx_data  (dev_rx_data),
        .dev_tx_ready (dev_tx_ready),
        .busy         (busy),
        .fin          (fin),
        .bus_req      (bus_req),
        .mem_valid    (mem_valid),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .dev_rx_ready (dev_rx_ready),
        .dev_tx_valid (dev_tx_valid),
        .dev_tx_data  (dev_tx_data)
    );

    assign irq      = done;
    assign dev_addr = cfg.dev;

    // Port-level checkers: words per request window and bytes per transfer.
    logic              word_moved;
    logic              bad_go;
    logic [SEEN_W-1:0] seen;
    logic [CNT_W-1:0]  moved;
    logic [CNT_W-1:0]  target;

    assign word_moved = mem_valid && mem_ready;
    assign bad_go = cfg_we && (reg_sel_e'(cfg_sel) == SEL_GO) && cfg_wdata[0]
                    && !busy && !count_ok(cfg.count);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen   <= '0;
            moved  <= '0;
            target <= '0;
        end else begin
            if (!bus_req)
                seen <= '0;
            else if (word_moved)
                seen <= seen + 1'b1;
            if (start) begin
                moved  <= '0;
                target <= cfg.count;
            end else if (word_moved) begin
                moved <= moved + CNT_W'(WORD_BYTES);
            end
        end
    end

    assert_burst_cap_R7: assert property (@(posedge clk) disable iff (rst)
        int'(seen) <= BURST_LEN)
        else $error("too many words under one request");

    assert_length_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (moved == target))
        else $error("transfer ended with wrong byte total");

    assert_bad_go_R2: assert property (@(posedge clk) disable iff (rst)
        bad_go |=> !busy)
        else $error("illegal count started a transfer");

endmodule

// File: tb/test_dma_xfer_ctrl.sv
module test_dma_xfer_ctrl;

    localparam int          BURST = 16;
    localparam logic [31:0] SRCB  = 32'hC0DE_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        busy, irq, bus_req;
    logic        bus_gnt = 1'b0;
    logic        mem_valid, mem_we;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  dev_addr;
    logic        dev_rx_valid = 1'b0;
    logic        dev_rx_ready;
    logic [31:0] dev_rx_data;
    logic        dev_tx_valid;
    logic        dev_tx_ready = 1'b0;
    logic [31:0] dev_tx_data;

    always #5 clk = ~clk;

    dma_xfer_ctrl i_dma_xfer_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_addr(dev_addr),
        .dev_rx_valid(dev_rx_valid), .dev_rx_ready(dev_rx_ready),
        .dev_rx_data(dev_rx_data), .dev_tx_valid(dev_tx_valid),
        .dev_tx_ready(dev_tx_ready), .dev_tx_data(dev_tx_data)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int mode = 0;
    int src_idx = 0;
    int tx_cnt = 0;
    logic [31:0] bmem [0:255];

    assign mem_rdata   = bmem[mem_addr[9:2]];
    assign dev_rx_data = SRCB + 32'(src_idx);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Environment: arbiter, memory and device readiness patterns.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (mode == 0) begin
            bus_gnt      = bus_req;
            mem_ready    = 1'b1;
            dev_rx_valid = 1'b1;
            dev_tx_ready = 1'b1;
        end else begin
            bus_gnt      = bus_req && (cyc % 7 != 3) && (cyc % 11 != 5);
            mem_ready    = (cyc % 3 != 0);
            dev_rx_valid = (cyc % 5 != 1);
            dev_tx_ready = (cyc % 4 != 2);
        end
    end

    always @(posedge clk) begin
        if (mem_valid && mem_ready && mem_we)
            bmem[mem_addr[9:2]] <= mem_wdata;
        if (dev_rx_valid && dev_rx_ready)
            src_idx <= src_idx + 1;
        if (dev_tx_valid && dev_tx_ready)
            tx_cnt <= tx_cnt + 1;
    end

    // Behavioural reference model, compared every cycle.
    logic [7:0]  m_dev = 0;
    logic [31:0] m_maddr = 0;
    logic [15:0] m_cnt = 0;
    bit          m_dir = 0;
    bit          exp_busy = 0, exp_irq = 0, exp_dir = 0, want_drop = 0;
    logic [31:0] exp_addr = 0;
    int          exp_left = 0, exp_src = 0, burst = 0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(busy == exp_busy, "R6 busy", 32'(busy), 32'(exp_busy));
            chk(irq == exp_irq, "R9 irq", 32'(irq), 32'(exp_irq));
            chk(dev_addr == m_dev, "R1 dev_addr", 32'(dev_addr), 32'(m_dev));
            if (want_drop) begin
                chk(!bus_req, "R7 request released", 32'(bus_req), 0);
                want_drop = 0;
            end
            if (!bus_req) burst = 0;
            if (mem_valid) begin
                chk(bus_req && bus_gnt, "R3 ownership", 32'(bus_gnt), 1);
                chk(mem_addr == exp_addr, "R4/R5 address", mem_addr, exp_addr);
                chk(mem_we == !exp_dir, "R4/R5 mem_we", 32'(mem_we), 32'(!exp_dir));
            end
            if (!mem_valid || !mem_ready) begin
                chk(!(dev_rx_valid && dev_rx_ready) && !(dev_tx_valid && dev_tx_ready),
                    "R8 lone device handshake", 32'(dev_rx_ready), 0);
            end else begin
                if (!exp_dir) begin
                    chk(dev_rx_valid && dev_rx_ready, "R4 device take", 32'(dev_rx_ready), 1);
                    chk(mem_wdata == SRCB + 32'(exp_src), "R4 data order", mem_wdata,
                        SRCB + 32'(exp_src));
                    exp_src++;
                end else begin
                    chk(dev_tx_valid && dev_tx_ready, "R5 device give", 32'(dev_tx_valid), 1);
                    chk(dev_tx_data == bmem[exp_addr[9:2]], "R5 data order", dev_tx_data,
                        bmem[exp_addr[9:2]]);
                end
                exp_addr += 4;
                exp_left -= 4;
                burst++;
                chk(burst <= BURST, "R7 burst cap", 32'(burst), BURST);
                if (exp_left == 0) begin
                    exp_busy = 0;
                    exp_irq  = 1;
                end else if (burst == BURST) begin
                    want_drop = 1;
                end
            end
            if (cfg_we) begin
                if (cfg_sel == 3'd4 && cfg_wdata[0] && !exp_busy) begin
                    if (m_cnt != 0 && m_cnt[1:0] == 0) begin
                        exp_busy = 1;
                        exp_addr = m_maddr;
                        exp_left = int'(m_cnt);
                        exp_dir  = m_dir;
                    end
                end else if (cfg_sel == 3'd5 && cfg_wdata[1]) begin
                    exp_irq = 0;
                end else if (!exp_busy) begin
                    case (cfg_sel)
                        3'd0: m_dev   = cfg_wdata[7:0];
                        3'd1: m_maddr = cfg_wdata;
                        3'd2: m_cnt   = cfg_wdata[15:0];
                        3'd3: m_dir   = cfg_wdata[0];
                        default: ;
                    endcase
                end
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        cfg_sel = a;
        @(negedge clk);
        d = cfg_rdata;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    logic [31:0] v;
    int          tx0;

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] <= 32'hA500_0000 + 32'(i);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!busy && !irq && !bus_req, "R1 reset outputs", {busy, irq, bus_req}, 0);
        rd(3'd5, v);
        chk(v == 0, "R1 reset status", v, 0);

        // R1/R4: programming and device-to-memory, no stalls
        wr(3'd0, 32'h3C); wr(3'd1, 32'h40); wr(3'd2, 32); wr(3'd3, 0);
        rd(3'd0, v); chk(v == 32'h3C, "R1 readback dev", v, 32'h3C);
        rd(3'd1, v); chk(v == 32'h40, "R1 readback maddr", v, 32'h40);
        rd(3'd2, v); chk(v == 32, "R1 readback count", v, 32);
        wr(3'd4, 1);
        @(negedge clk);
        chk(busy, "R2 busy after go", 32'(busy), 1);
        wait_idle();
        for (int k = 0; k < 8; k++)
            chk(bmem[16 + k] == SRCB + 32'(k), "R4 landed word", bmem[16 + k], SRCB + 32'(k));
        rd(3'd5, v); chk(v == 32'h2, "R9 done status", v, 32'h2);
        wr(3'd5, 2);

        // R8/R7: device-to-memory across bursts with stalls
        mode = 1;
        wr(3'd1, 32'h300); wr(3'd2, 80); wr(3'd4, 1);
        wait_idle();
        for (int k = 0; k < 20; k++)
            chk(bmem[192 + k] == SRCB + 32'(8 + k), "R8 stalled landing", bmem[192 + k],
                SRCB + 32'(8 + k));
        wr(3'd5, 2);

        // R5/R9: memory-to-device, 40 words with stalls
        tx0 = tx_cnt;
        wr(3'd1, 32'h100); wr(3'd2, 160); wr(3'd3, 1); wr(3'd4, 1);
        wait_idle();
        chk(tx_cnt - tx0 == 40, "R5 words delivered", 32'(tx_cnt - tx0), 40);
        wr(3'd5, 0);
        @(negedge clk);
        chk(irq, "R9 irq kept on write without done bit", 32'(irq), 1);
        wr(3'd5, 2);
        @(negedge clk);
        chk(!irq, "R9 irq cleared", 32'(irq), 0);

        // R10: writes and go during a transfer are ignored
        tx0 = tx_cnt;
        wr(3'd0, 32'h55); wr(3'd1, 32'h200); wr(3'd2, 96); wr(3'd4, 1);
        wr(3'd0, 32'hEE); wr(3'd1, 32'h80); wr(3'd2, 8); wr(3'd3, 0); wr(3'd4, 1);
        @(negedge clk);
        chk(busy && dev_addr == 8'h55, "R10 dev_addr frozen", 32'(dev_addr), 32'h55);
        wait_idle();
        chk(tx_cnt - tx0 == 24, "R10 no second transfer", 32'(tx_cnt - tx0), 24);
        rd(3'd0, v); chk(v == 32'h55, "R10 dev kept", v, 32'h55);
        rd(3'd1, v); chk(v == 32'h200, "R10 maddr kept", v, 32'h200);
        rd(3'd2, v); chk(v == 96, "R10 count kept", v, 96);
        rd(3'd3, v); chk(v == 1, "R10 dir kept", v, 1);
        wr(3'd5, 2);

        // R2: illegal counts
        wr(3'd2, 6); wr(3'd4, 1);
        repeat (3) begin
            @(negedge clk);
            chk(!busy && !bus_req, "R2 misaligned not started", 32'(bus_req), 0);
        end
        rd(3'd5, v); chk(v == 32'h4, "R2 error bit", v, 32'h4);
        wr(3'd5, 4);
        rd(3'd5, v); chk(v == 0, "R9 error cleared", v, 0);
        wr(3'd2, 0); wr(3'd4, 1);
        @(negedge clk);
        chk(!busy && !bus_req, "R2 zero count not started", 32'(busy), 0);
        rd(3'd5, v); chk(v == 32'h4, "R2 zero count error", v, 32'h4);
        wr(3'd5, 4);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule